// File: doc/BRIEF.md
# Bus Error Classifier and Retry Controller

This block sits next to the message engine of a MIL-STD-1553B bus controller. Each time the engine finishes a message attempt it pulses a completion strobe together with that attempt's error indications. The block sorts them into error groups and chooses one action: retry the message, continue with the next one, or abort the controller. It also records status-word flags and a message-okay bit for the transfer status word, and raises a dedicated interrupt for each kind of fatal fault.

Retryable errors come from four sources: decoder errors, loopback mismatch, a missing or late terminal response, and a busy or message-error bit in the status word. A per-message counter limits these retries to a bound set from 0 to 3. When the bound is reached and the error is still present, the controller aborts and reports the error group. A loopback failure is the exception: by default it continues instead. Memory, stack and instruction-list faults abort at once in any cycle. A CPU command gate drops start or asynchronous-message commands that arrive while an asynchronous message is already running.

Top module: `bc_err_retry`

## Requirements
- R1: A completion with any bit of `dec_err_i` set (bit 0 parity, bit 1 Manchester, bit 2 word count, bit 3 sync type) requests a retry while the per-message retry count `tries_o` is below `max_retry_i`. Each retry increments `tries_o`.
- R2: When a retryable error persists with `tries_o` equal to `max_retry_i` (0 to 3), the block pulses `abort_o` with `abort_code_o` set to the group: 1 decoder, 3 no response, 4 status busy or message error. `tries_o` returns to 0. Group priority is decoder, then loopback, then no response, then status.
- R3: A loopback failure requests a retry (group 2) and sets `lpbk_flag_o`, which then stays set until reset. With the default `LPBK_ABORT=0`, an exhausted loopback retry gives `cont_o` with `msg_ok_o` clear instead of an abort.
- R4: A completion with `no_resp_i` set is retried or aborted as group 3, and the status word is ignored: no status retry and `sw_flags_o` is 0.
- R5: A status word with busy (bit 3) or message error (bit 10) set, with a response present and no decoder error, is handled as group 4.
- R6: On each completion, status bits in the flag mask (bits 0, 1, 2, 4, 8, 9) are copied to `sw_flags_o` and cause no retry. All other status bits read as 0 in `sw_flags_o`.
- R7: A completion that ends in continue sets `msg_ok_o` only when no error group is present and `type_mismatch_i` is low. A type mismatch alone gives `cont_o` with `msg_ok_o` clear.
- R8: `mem_fault_i` in any cycle gives, one cycle later, `abort_o` with code 5 and a pulse on `irq_mem_o`. This overrides a simultaneous completion and clears `tries_o`.
- R9: `stk_fault_i` gives `abort_o` with code 6 and a pulse on `irq_stack_o`.
- R10: `ill_op_i` or `list_bad_i` gives `abort_o` with code 7 and a pulse on `irq_list_o`. Fault priority is memory, then stack, then list.
- R11: `start_cmd_i` or `async_cmd_i` is forwarded one cycle later on `start_go_o` or `async_go_o` when `async_active_i` is low. When `async_active_i` is high the command is dropped and `irq_ill_cmd_o` pulses.
- R12: After reset all pulses, `tries_o`, `msg_ok_o`, `sw_flags_o` and `lpbk_flag_o` are 0. Outputs appear in the cycle after their cause, pulses last one cycle, and each completion yields exactly one of retry, continue or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | Message attempt completed |
| dec_err_i | input | 4 | Decoder errors: parity, Manchester, word count, sync |
| lpbk_fail_i | input | 1 | Loopback comparison failed |
| no_resp_i | input | 1 | Terminal response absent or late |
| sw_i | input | 16 | Received status word |
| type_mismatch_i | input | 1 | Message block type disagrees with command word |
| mem_fault_i | input | 1 | Memory access failure strobe |
| stk_fault_i | input | 1 | Stack overflow or underflow strobe |
| ill_op_i | input | 1 | Illegal opcode strobe |
| list_bad_i | input | 1 | Corrupt instruction list strobe |
| max_retry_i | input | 2 | Retry bound, 0 to 3 |
| async_active_i | input | 1 | Asynchronous message in progress |
| start_cmd_i | input | 1 | CPU start command |
| async_cmd_i | input | 1 | CPU asynchronous message command |
| retry_o | output | 1 | Retry request pulse |
| cont_o | output | 1 | Continue pulse |
| abort_o | output | 1 | Abort request pulse |
| abort_code_o | output | 3 | Error group of the abort |
| tries_o | output | 2 | Retries issued for the current message |
| msg_ok_o | output | 1 | Message-okay bit of the transfer status |
| sw_flags_o | output | 16 | Recorded status-word flag bits |
| lpbk_flag_o | output | 1 | Sticky loopback failure bit |
| irq_mem_o | output | 1 | Memory failure interrupt pulse |
| irq_stack_o | output | 1 | Stack fault interrupt pulse |
| irq_list_o | output | 1 | Corrupt instruction list interrupt pulse |
| irq_ill_cmd_o | output | 1 | Illegal command interrupt pulse |
| start_go_o | output | 1 | Accepted start command |
| async_go_o | output | 1 | Accepted asynchronous command |

## Verification
The hardest case to reach is the exact retry boundary: abort or continue must appear on the attempt after `max_retry_i` retries, never sooner. The stimulus therefore sweeps every bound from 0 to 3 against every retryable error source and repeats the failing attempt bound-plus-one times. A second hard case is a fault that lands on a completion while retries are pending. The bench builds up a retry count first, then raises the fault together with the strobe, so it can see the fault override the completion and the count clear.

// File: rtl/bcer_pkg.sv
package bcer_pkg;
   typedef enum logic [2:0] {
      GRP_NONE   = 3'd0,
      GRP_SIGNAL = 3'd1,
      GRP_LOOP   = 3'd2,
      GRP_RESP   = 3'd3,
      GRP_STATUS = 3'd4,
      GRP_MEM    = 3'd5,
      GRP_STACK  = 3'd6,
      GRP_LIST   = 3'd7
   } grp_e;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_RETRY = 2'd1,
      ACT_CONT  = 2'd2,
      ACT_ABORT = 2'd3
   } act_e;
endpackage

// File: rtl/bcer_classify.sv
module bcer_classify
   import bcer_pkg::*;
#(
   parameter int          SW_W      = 16,
   parameter int          DEC_W     = 4,
   parameter int          BUSY_BIT  = 3,
   parameter int          MERR_BIT  = 10,
   parameter logic [15:0] FLAG_MASK = 16'h0317
) (
   input  logic [DEC_W-1:0] dec_err_i,
   input  logic             lpbk_fail_i,
   input  logic             no_resp_i,
   input  logic [SW_W-1:0]  sw_i,
   output grp_e             grp_o,
   output logic [SW_W-1:0]  flags_o
);
   logic sw_valid;
   logic dec_any;
   logic status_retry;

   assign dec_any      = |dec_err_i;
   assign sw_valid     = !no_resp_i && !dec_any;
   assign status_retry = sw_valid && (sw_i[BUSY_BIT] || sw_i[MERR_BIT]);

   for (genvar b = 0; b < SW_W; b++) begin : g_flag
      if (FLAG_MASK[b]) begin : g_kept
         assign flags_o[b] = sw_valid && sw_i[b];
      end else begin : g_dropped
         assign flags_o[b] = 1'b0;
      end
   end

   always_comb begin
      if (dec_any)           grp_o = GRP_SIGNAL;
      else if (lpbk_fail_i)  grp_o = GRP_LOOP;
      else if (no_resp_i)    grp_o = GRP_RESP;
      else if (status_retry) grp_o = GRP_STATUS;
      else                   grp_o = GRP_NONE;
   end
endmodule

// File: rtl/bcer_retry_seq.sv
module bcer_retry_seq
   import bcer_pkg::*;
#(
   parameter int RTRY_W     = 2,
   parameter bit LPBK_ABORT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eval_i,
   input  grp_e              grp_i,
   input  grp_e              fault_i,
   input  logic              lpbk_i,
   input  logic              mismatch_i,
   input  logic [RTRY_W-1:0] max_i,
   output logic              retry_o,
   output logic              cont_o,
   output logic              abort_o,
   output grp_e              code_o,
   output logic [RTRY_W-1:0] tries_o,
   output logic              msg_ok_o,
   output logic              lpbk_o,
   output logic              irq_mem_o,
   output logic              irq_stack_o,
   output logic              irq_list_o
);
   logic              loop_escalates;
   act_e              nxt_act;
   grp_e              nxt_code;
   logic [RTRY_W-1:0] cnt_q;
   logic              live_eval;

   if (LPBK_ABORT) begin : g_loop_abort
      assign loop_escalates = 1'b1;
   end else begin : g_loop_cont
      assign loop_escalates = 1'b0;
   end

   assign live_eval = eval_i && (fault_i == GRP_NONE);

   always_comb begin
      nxt_act  = ACT_NONE;
      nxt_code = GRP_NONE;
      if (fault_i != GRP_NONE) begin
         nxt_act  = ACT_ABORT;
         nxt_code = fault_i;
      end else if (eval_i) begin
         if (grp_i == GRP_NONE) begin
            nxt_act = ACT_CONT;
         end else if (cnt_q < max_i) begin
            nxt_act = ACT_RETRY;
         end else if (grp_i == GRP_LOOP && !loop_escalates) begin
            nxt_act = ACT_CONT;
         end else begin
            nxt_act  = ACT_ABORT;
            nxt_code = grp_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         retry_o     <= 1'b0;
         cont_o      <= 1'b0;
         abort_o     <= 1'b0;
         code_o      <= GRP_NONE;
         cnt_q       <= '0;
         msg_ok_o    <= 1'b0;
         lpbk_o      <= 1'b0;
         irq_mem_o   <= 1'b0;
         irq_stack_o <= 1'b0;
         irq_list_o  <= 1'b0;
      end else begin
         retry_o     <= (nxt_act == ACT_RETRY);
         cont_o      <= (nxt_act == ACT_CONT);
         abort_o     <= (nxt_act == ACT_ABORT);
         code_o      <= nxt_code;
         irq_mem_o   <= (fault_i == GRP_MEM);
         irq_stack_o <= (fault_i == GRP_STACK);
         irq_list_o  <= (fault_i == GRP_LIST);
         if (nxt_act == ACT_RETRY) begin
            cnt_q <= cnt_q + RTRY_W'(1);
         end else if (nxt_act == ACT_CONT || nxt_act == ACT_ABORT) begin
            cnt_q <= '0;
         end
         if (live_eval) begin
            msg_ok_o <= (nxt_act == ACT_CONT) && (grp_i == GRP_NONE) && !mismatch_i;
            if (lpbk_i) lpbk_o <= 1'b1;
         end
      end
   end

   assign tries_o = cnt_q;

   assert_one_action_R12: assert property (@(posedge clk) disable iff (!rst_n)
      live_eval |=> $onehot({retry_o, cont_o, abort_o}));

   assert_exhaust_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
      live_eval && grp_i != GRP_NONE && grp_i != GRP_LOOP && cnt_q >= max_i
      |=> abort_o && !retry_o);

   assert_lpbk_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lpbk_o |=> lpbk_o);

   assert_retry_counts_R1: assert property (@(posedge clk) disable iff (!rst_n)
      retry_o |-> tries_o != '0);
endmodule

// File: rtl/bcer_cmd_gate.sv
module bcer_cmd_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic active_i,
   input  logic start_i,
   input  logic async_i,
   output logic start_go_o,
   output logic async_go_o,
   output logic irq_ill_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_go_o <= 1'b0;
         async_go_o <= 1'b0;
         irq_ill_o  <= 1'b0;
      end else begin
         start_go_o <= start_i && !active_i;
         async_go_o <= async_i && !active_i;
         irq_ill_o  <= (start_i || async_i) && active_i;
      end
   end

   assert_ill_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i || async_i) && active_i |=> irq_ill_o && !start_go_o && !async_go_o);

   assert_cmd_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !active_i |=> start_go_o && !irq_ill_o);
endmodule

// File: rtl/bc_err_retry.sv
module bc_err_retry
   import bcer_pkg::*;
#(
   parameter int          SW_W       = 16,
   parameter int          DEC_W      = 4,
   parameter int          RTRY_W     = 2,
   parameter int          BUSY_BIT   = 3,
   parameter int          MERR_BIT   = 10,
   parameter logic [15:0] FLAG_MASK  = 16'h0317,
   parameter bit          LPBK_ABORT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DEC_W-1:0]  dec_err_i,
   input  logic              lpbk_fail_i,
   input  logic              no_resp_i,
   input  logic [SW_W-1:0]   sw_i,
   input  logic              type_mismatch_i,
   input  logic              mem_fault_i,
   input  logic              stk_fault_i,
   input  logic              ill_op_i,
   input  logic              list_bad_i,
   input  logic [RTRY_W-1:0] max_retry_i,
   input  logic              async_active_i,
   input  logic              start_cmd_i,
   input  logic              async_cmd_i,
   output logic              retry_o,
   output logic              cont_o,
   output logic              abort_o,
   output logic [2:0]        abort_code_o,
   output logic [RTRY_W-1:0] tries_o,
   output logic              msg_ok_o,
   output logic [SW_W-1:0]   sw_flags_o,
   output logic              lpbk_flag_o,
   output logic              irq_mem_o,
   output logic              irq_stack_o,
   output logic              irq_list_o,
   output logic              irq_ill_cmd_o,
   output logic              start_go_o,
   output logic              async_go_o
);
   localparam int MASK_BITS = (SW_W < 16) ? SW_W : 16;

   if (SW_W < 11 || SW_W > 16) begin : g_bad_sw
      $error("status word width must be 11 to 16");
   end
   if (RTRY_W < 1 || RTRY_W > 4) begin : g_bad_rtry
      $error("retry counter width out of range");
   end
   if (BUSY_BIT >= SW_W || MERR_BIT >= SW_W || BUSY_BIT == MERR_BIT) begin : g_bad_bits
      $error("busy and message-error positions invalid");
   end
   if (FLAG_MASK[BUSY_BIT] || FLAG_MASK[MERR_BIT]) begin : g_bad_mask
      $error("flag mask must exclude retry bits");
   end

   grp_e            cls_grp;
   grp_e            fault_grp;
   grp_e            code_q;
   logic [SW_W-1:0] cls_flags;
   logic [SW_W-1:0] flags_q;

   always_comb begin
      if (mem_fault_i)                  fault_grp = GRP_MEM;
      else if (stk_fault_i)             fault_grp = GRP_STACK;
      else if (ill_op_i || list_bad_i)  fault_grp = GRP_LIST;
      else                              fault_grp = GRP_NONE;
   end

   bcer_classify #(
      .SW_W      (SW_W),
      .DEC_W     (DEC_W),
      .BUSY_BIT  (BUSY_BIT),
      .MERR_BIT  (MERR_BIT),
      .FLAG_MASK (FLAG_MASK)
   ) u_classify (
      .dec_err_i   (dec_err_i),
      .lpbk_fail_i (lpbk_fail_i),
      .no_resp_i   (no_resp_i),
      .sw_i        (sw_i),
      .grp_o       (cls_grp),
      .flags_o     (cls_flags)
   );

   bcer_retry_seq #(
      .RTRY_W     (RTRY_W),
      .LPBK_ABORT (LPBK_ABORT)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .eval_i      (done_i),
      .grp_i       (cls_grp),
      .fault_i     (fault_grp),
      .lpbk_i      (lpbk_fail_i),
      .mismatch_i  (type_mismatch_i),
      .max_i       (max_retry_i),
      .retry_o     (retry_o),
      .cont_o      (cont_o),
      .abort_o     (abort_o),
      .code_o      (code_q),
      .tries_o     (tries_o),
      .msg_ok_o    (msg_ok_o),
      .lpbk_o      (lpbk_flag_o),
      .irq_mem_o   (irq_mem_o),
      .irq_stack_o (irq_stack_o),
      .irq_list_o  (irq_list_o)
   );

   bcer_cmd_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_i   (async_active_i),
      .start_i    (start_cmd_i),
      .async_i    (async_cmd_i),
      .start_go_o (start_go_o),
      .async_go_o (async_go_o),
      .irq_ill_o  (irq_ill_cmd_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (done_i && fault_grp == GRP_NONE) begin
         flags_q <= cls_flags;
      end
   end

   assign abort_code_o = code_q;
   assign sw_flags_o   = flags_q;

   assert_mem_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_fault_i |=> abort_o && irq_mem_o && abort_code_o == 3'd5 && tries_o == '0);

   assert_stack_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stk_fault_i && !mem_fault_i |=> abort_o && irq_stack_o && !irq_mem_o);

   assert_list_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ill_op_i || list_bad_i) && !mem_fault_i && !stk_fault_i
      |=> abort_o && irq_list_o && abort_code_o == 3'd7);

   assert_dec_no_cont_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && (|dec_err_i) |=> !cont_o);

   assert_noresp_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done_i && no_resp_i && !mem_fault_i && !stk_fault_i && !ill_op_i && !list_bad_i
      |=> sw_flags_o == '0);

   assert_unmasked_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_flags_o & ~SW_W'(FLAG_MASK[MASK_BITS-1:0])) == '0);
endmodule

// File: tb/bc_err_retry_tb.sv
module bc_err_retry_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        done_i = 1'b0;
   logic [3:0]  dec_err_i = '0;
   logic        lpbk_fail_i = 1'b0;
   logic        no_resp_i = 1'b0;
   logic [15:0] sw_i = '0;
   logic        type_mismatch_i = 1'b0;
   logic        mem_fault_i = 1'b0;
   logic        stk_fault_i = 1'b0;
   logic        ill_op_i = 1'b0;
   logic        list_bad_i = 1'b0;
   logic [1:0]  max_retry_i = '0;
   logic        async_active_i = 1'b0;
   logic        start_cmd_i = 1'b0;
   logic        async_cmd_i = 1'b0;
   logic        retry_o, cont_o, abort_o, msg_ok_o, lpbk_flag_o;
   logic [2:0]  abort_code_o;
   logic [1:0]  tries_o;
   logic [15:0] sw_flags_o;
   logic        irq_mem_o, irq_stack_o, irq_list_o, irq_ill_cmd_o, start_go_o, async_go_o;

   int checks = 0;
   int errors = 0;

   localparam logic [15:0] MASK = 16'h0317;

   always #5 clk = ~clk;

   bc_err_retry u_dut (
      .clk(clk), .rst_n(rst_n), .done_i(done_i), .dec_err_i(dec_err_i),
      .lpbk_fail_i(lpbk_fail_i), .no_resp_i(no_resp_i), .sw_i(sw_i),
      .type_mismatch_i(type_mismatch_i), .mem_fault_i(mem_fault_i),
      .stk_fault_i(stk_fault_i), .ill_op_i(ill_op_i), .list_bad_i(list_bad_i),
      .max_retry_i(max_retry_i), .async_active_i(async_active_i),
      .start_cmd_i(start_cmd_i), .async_cmd_i(async_cmd_i),
      .retry_o(retry_o), .cont_o(cont_o), .abort_o(abort_o),
      .abort_code_o(abort_code_o), .tries_o(tries_o), .msg_ok_o(msg_ok_o),
      .sw_flags_o(sw_flags_o), .lpbk_flag_o(lpbk_flag_o), .irq_mem_o(irq_mem_o),
      .irq_stack_o(irq_stack_o), .irq_list_o(irq_list_o),
      .irq_ill_cmd_o(irq_ill_cmd_o), .start_go_o(start_go_o), .async_go_o(async_go_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // action vector: {retry, cont, abort, code[2:0]}
   function automatic logic [31:0] actv();
      return {26'd0, retry_o, cont_o, abort_o, abort_code_o};
   endfunction

   function automatic logic [31:0] mk(input logic r, input logic c, input logic a, input logic [2:0] cd);
      return {26'd0, r, c, a, cd};
   endfunction

   task automatic clear_in();
      done_i = 0; dec_err_i = '0; lpbk_fail_i = 0; no_resp_i = 0; sw_i = '0;
      type_mismatch_i = 0; mem_fault_i = 0; stk_fault_i = 0; ill_op_i = 0;
      list_bad_i = 0; start_cmd_i = 0; async_cmd_i = 0;
   endtask

   // Inputs held over one rising edge, then outputs are sampled at the next falling edge.
   task automatic step();
      @(negedge clk);
      clear_in();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic exp_lp;
      exp_lp = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R12 reset state
      chk("R12 reset actions", actv(), mk(0, 0, 0, 0));
      chk("R12 reset state", {tries_o, msg_ok_o, lpbk_flag_o, sw_flags_o},
          {2'd0, 1'b0, 1'b0, 16'h0});
      chk("R12 reset irqs", {irq_mem_o, irq_stack_o, irq_list_o, irq_ill_cmd_o}, 4'h0);

      // Sweep retry bound against every retryable source (R1 R2 R3 R4 R5)
      for (int mr = 0; mr < 4; mr++) begin
         for (int k = 0; k < 5; k++) begin
            max_retry_i = 2'(mr);
            for (int a = 0; a <= mr; a++) begin
               done_i = 1;
               case (k)
                  0: dec_err_i = 4'(1 << (a % 4));
                  1: lpbk_fail_i = 1;
                  2: no_resp_i = 1;
                  3: sw_i = 16'h0008;
                  default: sw_i = 16'h0400;
               endcase
               if (k == 1) exp_lp = 1;
               step();
               if (a < mr) begin
                  chk("R1 retry issued", actv(), mk(1, 0, 0, 0));
                  chk("R1 tries count", 32'(tries_o), 32'(a + 1));
               end else if (k == 1) begin
                  chk("R3 loopback exhausted continues", actv(), mk(0, 1, 0, 0));
                  chk("R3 msg ok clear", 32'(msg_ok_o), 0);
               end else begin
                  chk("R2 exhausted abort", actv(),
                      mk(0, 0, 1, (k == 0) ? 3'd1 : (k == 2) ? 3'd3 : 3'd4));
                  chk("R2 tries cleared", 32'(tries_o), 0);
               end
               chk("R3 loopback flag", 32'(lpbk_flag_o), 32'(exp_lp));
            end
            step();
            chk("R12 idle after completion", actv(), mk(0, 0, 0, 0));
         end
      end

      // Recovery after one retry (R7 R1)
      max_retry_i = 2;
      done_i = 1; dec_err_i = 4'h4; step();
      chk("R1 first attempt retries", actv(), mk(1, 0, 0, 0));
      done_i = 1; step();
      chk("R7 clean continue", actv(), mk(0, 1, 0, 0));
      chk("R7 msg ok set", {30'd0, msg_ok_o, tries_o == 2'd0}, 32'h3);

      // Type mismatch (R7)
      done_i = 1; type_mismatch_i = 1; step();
      chk("R7 mismatch continue", actv(), mk(0, 1, 0, 0));
      chk("R7 mismatch msg ok clear", 32'(msg_ok_o), 0);

      // Status bit sweep with bound 0 (R5 R6)
      max_retry_i = 0;
      for (int b = 0; b < 16; b++) begin
         done_i = 1; sw_i = 16'(1 << b); step();
         if (b == 3 || b == 10) chk("R5 status retry group", actv(), mk(0, 0, 1, 4));
         else begin
            chk("R6 flag bit continues", actv(), mk(0, 1, 0, 0));
            chk("R6 msg ok", 32'(msg_ok_o), 1);
         end
         chk("R6 recorded flags", 32'(sw_flags_o), 32'(16'(1 << b) & MASK));
      end

      // No response hides status word (R4)
      done_i = 1; no_resp_i = 1; sw_i = 16'hFFFF; step();
      chk("R4 no response group", actv(), mk(0, 0, 1, 3));
      chk("R4 status ignored", 32'(sw_flags_o), 0);

      // Fault overriding pending retries (R8)
      max_retry_i = 3;
      done_i = 1; dec_err_i = 4'h1; step();
      chk("R1 retry before fault", 32'(tries_o), 1);
      done_i = 1; dec_err_i = 4'h1; mem_fault_i = 1; step();
      chk("R8 memory abort", actv(), mk(0, 0, 1, 5));
      chk("R8 irq and tries", {irq_mem_o, irq_stack_o, irq_list_o, 1'b0, 2'b0, tries_o}, 32'h80);
      step();
      chk("R12 irq is a pulse", {irq_mem_o, abort_o}, 2'b00);

      // Fault priority and each fault alone (R9 R10)
      mem_fault_i = 1; stk_fault_i = 1; step();
      chk("R10 priority mem over stack", {irq_mem_o, irq_stack_o, abort_code_o}, {2'b10, 3'd5});
      stk_fault_i = 1; ill_op_i = 1; step();
      chk("R9 stack abort", {irq_stack_o, irq_list_o, abort_o, abort_code_o}, {3'b101, 3'd6});
      ill_op_i = 1; step();
      chk("R10 illegal opcode", {irq_list_o, abort_o, abort_code_o}, {2'b11, 3'd7});
      list_bad_i = 1; step();
      chk("R10 corrupt list", {irq_list_o, irq_mem_o, abort_o, abort_code_o}, {3'b101, 3'd7});

      // Command gate sweep (R11)
      for (int v = 0; v < 8; v++) begin
         async_active_i = v[2]; start_cmd_i = v[1]; async_cmd_i = v[0];
         step();
         chk("R11 command gate", {start_go_o, async_go_o, irq_ill_cmd_o},
             {v[1] & ~v[2], v[0] & ~v[2], (v[1] | v[0]) & v[2]});
      end
      async_active_i = 0;
      step();
      chk("R12 gate idle", {start_go_o, async_go_o, irq_ill_cmd_o}, 3'b000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule